// File: doc/BRIEF.md
# Serial Programming-Port Code-Read Sequencer

This block is the host end of a two-wire programming link: one clock line that the host always drives, and one bidirectional data line. A single start request supplies a 22-bit start address and a byte count. The block then produces every clock and data waveform needed to read that many consecutive bytes from the target's code space. Each returned byte is handed to the rest of the chip with a one-cycle strobe.

A transfer begins with a fixed pointer-load program. This is six core-instruction frames made of load-literal and move-to-pointer-register pairs, which set the target's three-byte table pointer. After that the block issues read-with-post-increment frames back to back. The target advances its own pointer after each read, so no further pointer loads are needed. In every read frame the host drives zeros during the first eight payload clocks and then lets go of the data line. It holds the clock low for a programmable turnaround time and then clocks the returned byte in, least significant bit first.

When the target reports read protection, the first byte read from each protected block is thrown away. The pointer is loaded again and the read is repeated. The clock high time, the clock low time and the turnaround time each come from their own cycle-count input.

Top module: `pgm_read_seq`

## Requirements
- R1: A transfer with a non-zero count opens with six core-instruction frames. Each frame is the code 0000 followed by a 16-bit word, and all 20 bits are sent least significant bit first. The words, in order, are 0x0E00|A[21:16], 0x6EF8, 0x0E00|A[15:8], 0x6EF7, 0x0E00|A[7:0], 0x6EF6, where A is the address of the next byte to be delivered. No read frame is sent before all six have been sent.
- R2: Each byte is read with a 20-bit frame: the code 1001 (bit 0 = 1), then 16 payload clocks. The host drives the data line low during payload clocks 1 to 8.
- R3: The data-line output enable is low (released) for exactly clocks 13 to 20 of a read frame and high at every other time. The enable changes only while the clock is low.
- R4: In a read frame, the low phase before clock 13 lasts max(t_lo,1) + t_turn system cycles.
- R5: Every clock high phase lasts max(t_hi,1) cycles. Every low phase inside a frame, other than the one in R4, lasts max(t_lo,1) cycles.
- R6: The returned byte is sampled in the last high cycle of clocks 13 to 20, least significant bit first. It is presented on byte_o with a one-cycle byte_vld_o strobe and its 22-bit address on byte_addr_o.
- R7: Consecutive bytes are read with no further pointer load when protection is off. Addresses step by one and wrap from 0x3FFFFF to 0x000000.
- R8: With rd_prot_i set at the start, the first read in the start block, and the first read in each new block entered (address low BLK_BITS bits all zero), is discarded and never presented. The pointer-load program is then repeated for the same address, and the read is repeated.
- R9: busy_o rises in the cycle after an accepted start and stays high until done_o. done_o is high for exactly one cycle, in the first cycle that busy_o is low. A start request while busy_o is high is ignored.
- R10: A start with count zero produces no clock pulses and no bytes, only a done_o pulse. Otherwise exactly count bytes are delivered.
- R11: After reset the clock and data lines are low, the output enable is high, and busy_o, done_o and byte_vld_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, accepted when not busy |
| addr_i | input | 22 | Start address |
| count_i | input | CNT_W | Number of bytes to deliver |
| rd_prot_i | input | 1 | Target reports read protection |
| t_hi_i | input | TIM_W | Clock high time in cycles (0 acts as 1) |
| t_lo_i | input | TIM_W | Clock low time in cycles (0 acts as 1) |
| t_turn_i | input | TIM_W | Extra low time before the first input clock |
| ser_dat_i | input | 1 | Data line value returned by the target |
| ser_clk_o | output | 1 | Programming clock |
| ser_dat_o | output | 1 | Data line value driven by the host |
| ser_dat_oe_o | output | 1 | Data line output enable (1 = host drives) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| byte_vld_o | output | 1 | One-cycle strobe for byte_o and byte_addr_o |
| byte_o | output | 8 | Captured byte |
| byte_addr_o | output | 22 | Address of the captured byte |

## Verification
The assertions take for granted that t_hi_i, t_lo_i and t_turn_i do not change while busy_o is high. The high-width check compares against the current input value. They also assume the target keeps ser_dat_i stable through each high phase of an input clock. The bench changes the timing inputs only between transfers, with the block idle. Its target model updates the data line only just after a rising clock edge. Random addresses, counts, protection settings and timings are drawn inside these limits. Directed cases cover the address wrap, block crossings under protection, zero timings, a count of zero and a start request during a transfer.

// File: rtl/prs_pkg.sv
// Shared constants, state types and the pointer-load word table for the
// programming-port read sequencer. Assumes a 22-bit target address space.
package prs_pkg;
    localparam int ADDR_W      = 22;
    localparam int FRAME_BITS  = 20;
    localparam int CMD_BITS    = 4;
    localparam int SETUP_STEPS = 6;
    localparam int FIRST_IN    = 12;   // bit index of the first input clock in a read
    localparam int BIDX_W      = $clog2(FRAME_BITS);

    localparam logic [CMD_BITS-1:0] CMD_CORE      = 4'b0000;
    localparam logic [CMD_BITS-1:0] CMD_TREAD_INC = 4'b1001;

    typedef enum logic [2:0] {
        C_IDLE, C_SETUP, C_SWAIT, C_READ, C_RWAIT, C_FIN
    } ctrl_st_t;

    typedef enum logic [1:0] {
        E_IDLE, E_LOW, E_HIGH
    } eng_st_t;

    // Word for pointer-load step 0..5 aimed at address a.
    function automatic logic [15:0] setup_word(input logic [2:0] step,
                                               input logic [ADDR_W-1:0] a);
        logic [15:0] w;
        case (step)
            3'd0:    w = {8'h0E, 2'b00, a[21:16]};
            3'd1:    w = 16'h6EF8;
            3'd2:    w = {8'h0E, a[15:8]};
            3'd3:    w = 16'h6EF7;
            3'd4:    w = {8'h0E, a[7:0]};
            default: w = 16'h6EF6;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/prs_bit_engine.sv
// Serialises one 20-bit frame on the programming clock/data pair.
// Each bit is a low phase (data set up) followed by a high phase. In a read
// frame the last eight bits are inputs: the line is released and the low
// phase before the first of them is stretched by the turnaround time.
// Assumes go_i only while idle and the timing inputs stable for the frame.
module prs_bit_engine
    import prs_pkg::*;
#(
    parameter int TIM_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic                  rd_i,
    input  logic [TIM_W-1:0]      t_hi_i,
    input  logic [TIM_W-1:0]      t_lo_i,
    input  logic [TIM_W-1:0]      t_turn_i,
    input  logic                  sdi_i,
    output logic                  clk_o,
    output logic                  dat_o,
    output logic                  oe_o,
    output logic                  fin_o,
    output logic [7:0]            rx_o
);
    localparam int CW = TIM_W + 1;

    eng_st_t                 st;
    logic [CW-1:0]           cnt;
    logic [BIDX_W-1:0]       bidx;
    logic [FRAME_BITS-2:0]   sh;
    logic                    rdm;
    logic [BIDX_W-1:0]       bnext;
    logic [CW-1:0]           hi_len, lo_len, turn_ext;

    // Phase lengths with zero inputs clamped to one cycle.
    always_comb begin
        hi_len   = (t_hi_i == '0) ? '0 : CW'(t_hi_i) - CW'(1);
        lo_len   = (t_lo_i == '0) ? '0 : CW'(t_lo_i) - CW'(1);
        turn_ext = CW'(t_turn_i);
        bnext    = bidx + BIDX_W'(1);
    end

    // Bit sequencing, clock/data generation and input capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= E_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            sh    <= '0;
            rdm   <= 1'b0;
            clk_o <= 1'b0;
            dat_o <= 1'b0;
            oe_o  <= 1'b1;
            fin_o <= 1'b0;
            rx_o  <= '0;
        end else begin
            fin_o <= 1'b0;
            case (st)
                E_IDLE: begin
                    if (go_i) begin
                        sh    <= frame_i[FRAME_BITS-1:1];
                        dat_o <= frame_i[0];
                        rdm   <= rd_i;
                        bidx  <= '0;
                        cnt   <= lo_len;
                        oe_o  <= 1'b1;
                        st    <= E_LOW;
                    end
                end
                E_LOW: begin
                    if (cnt == '0) begin
                        clk_o <= 1'b1;
                        cnt   <= hi_len;
                        st    <= E_HIGH;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                E_HIGH: begin
                    if (cnt == '0) begin
                        clk_o <= 1'b0;
                        if (rdm && bidx >= BIDX_W'(FIRST_IN))
                            rx_o <= {sdi_i, rx_o[7:1]};
                        if (bidx == BIDX_W'(FRAME_BITS-1)) begin
                            fin_o <= 1'b1;
                            oe_o  <= 1'b1;
                            dat_o <= 1'b0;
                            st    <= E_IDLE;
                        end else begin
                            bidx  <= bnext;
                            dat_o <= sh[0];
                            sh    <= {1'b0, sh[FRAME_BITS-2:1]};
                            oe_o  <= !(rdm && bnext >= BIDX_W'(FIRST_IN));
                            cnt   <= (rdm && bnext == BIDX_W'(FIRST_IN)) ?
                                     lo_len + turn_ext : lo_len;
                            st    <= E_LOW;
                        end
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: st <= E_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/prs_ctrl.sv
// Transfer controller: accepts a request, runs the six-frame pointer load,
// then issues read frames and delivers bytes. Under protection the first
// read of each block is discarded and the pointer load repeated.
// Assumes one frame in flight at a time, acknowledged by eng_fin_i.
module prs_ctrl
    import prs_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int BLK_BITS = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [CNT_W-1:0]      count_i,
    input  logic                  prot_i,
    input  logic                  eng_fin_i,
    input  logic [7:0]            eng_rx_i,
    output logic                  eng_go_o,
    output logic [FRAME_BITS-1:0] eng_frame_o,
    output logic                  eng_rd_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  vld_o,
    output logic [7:0]            data_o,
    output logic [ADDR_W-1:0]     vaddr_o
);
    ctrl_st_t           st;
    logic [2:0]         step;
    logic [ADDR_W-1:0]  cur;
    logic [ADDR_W-1:0]  cur_nxt;
    logic [CNT_W-1:0]   remain;
    logic               prot_q;
    logic               fresh;
    logic               nxt_blk;

    // Next address and whether it opens a new block.
    always_comb begin
        cur_nxt = cur + ADDR_W'(1);
        nxt_blk = (cur_nxt[BLK_BITS-1:0] == '0);
        busy_o  = (st != C_IDLE);
    end

    // Transfer state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= C_IDLE;
            step        <= '0;
            cur         <= '0;
            remain      <= '0;
            prot_q      <= 1'b0;
            fresh       <= 1'b0;
            eng_go_o    <= 1'b0;
            eng_frame_o <= '0;
            eng_rd_o    <= 1'b0;
            done_o      <= 1'b0;
            vld_o       <= 1'b0;
            data_o      <= '0;
            vaddr_o     <= '0;
        end else begin
            eng_go_o <= 1'b0;
            done_o   <= 1'b0;
            vld_o    <= 1'b0;
            case (st)
                C_IDLE: begin
                    if (start_i) begin
                        cur    <= addr_i;
                        remain <= count_i;
                        prot_q <= prot_i;
                        fresh  <= 1'b1;
                        step   <= '0;
                        st     <= (count_i == '0) ? C_FIN : C_SETUP;
                    end
                end
                C_SETUP: begin
                    eng_go_o    <= 1'b1;
                    eng_rd_o    <= 1'b0;
                    eng_frame_o <= {setup_word(step, cur), CMD_CORE};
                    st          <= C_SWAIT;
                end
                C_SWAIT: begin
                    if (eng_fin_i) begin
                        if (step == 3'(SETUP_STEPS-1)) begin
                            st <= C_READ;
                        end else begin
                            step <= step + 3'd1;
                            st   <= C_SETUP;
                        end
                    end
                end
                C_READ: begin
                    eng_go_o    <= 1'b1;
                    eng_rd_o    <= 1'b1;
                    eng_frame_o <= {16'h0000, CMD_TREAD_INC};
                    st          <= C_RWAIT;
                end
                C_RWAIT: begin
                    if (eng_fin_i) begin
                        if (prot_q && fresh) begin
                            fresh <= 1'b0;
                            step  <= '0;
                            st    <= C_SETUP;
                        end else begin
                            vld_o   <= 1'b1;
                            data_o  <= eng_rx_i;
                            vaddr_o <= cur;
                            cur     <= cur_nxt;
                            remain  <= remain - CNT_W'(1);
                            fresh   <= nxt_blk;
                            st      <= (remain == CNT_W'(1)) ? C_FIN : C_READ;
                        end
                    end
                end
                C_FIN: begin
                    done_o <= 1'b1;
                    st     <= C_IDLE;
                end
                default: st <= C_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgm_read_seq.sv
// Top of the programming-port code-read sequencer: joins the transfer
// controller to the bit engine. Assumes timing inputs are held stable
// while busy and ser_dat_i is already in the system clock domain.
module pgm_read_seq
    import prs_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TIM_W    = 8,
    parameter int BLK_BITS = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [21:0]       addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              rd_prot_i,
    input  logic [TIM_W-1:0]  t_hi_i,
    input  logic [TIM_W-1:0]  t_lo_i,
    input  logic [TIM_W-1:0]  t_turn_i,
    input  logic              ser_dat_i,
    output logic              ser_clk_o,
    output logic              ser_dat_o,
    output logic              ser_dat_oe_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              byte_vld_o,
    output logic [7:0]        byte_o,
    output logic [21:0]       byte_addr_o
);
    logic                  go;
    logic [FRAME_BITS-1:0] frame;
    logic                  rd;
    logic                  fin;
    logic [7:0]            rx;

    prs_ctrl #(.CNT_W(CNT_W), .BLK_BITS(BLK_BITS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .addr_i     (addr_i),
        .count_i    (count_i),
        .prot_i     (rd_prot_i),
        .eng_fin_i  (fin),
        .eng_rx_i   (rx),
        .eng_go_o   (go),
        .eng_frame_o(frame),
        .eng_rd_o   (rd),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .vld_o      (byte_vld_o),
        .data_o     (byte_o),
        .vaddr_o    (byte_addr_o)
    );

    prs_bit_engine #(.TIM_W(TIM_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (go),
        .frame_i (frame),
        .rd_i    (rd),
        .t_hi_i  (t_hi_i),
        .t_lo_i  (t_lo_i),
        .t_turn_i(t_turn_i),
        .sdi_i   (ser_dat_i),
        .clk_o   (ser_clk_o),
        .dat_o   (ser_dat_o),
        .oe_o    (ser_dat_oe_o),
        .fin_o   (fin),
        .rx_o    (rx)
    );
endmodule

// File: rtl/pgm_read_seq_chk.sv
// Port-level protocol checker for pgm_read_seq, attached by bind.
// Assumes timing inputs stable while busy_o is high.
module pgm_read_seq_chk #(
    parameter int CNT_W = 16,
    parameter int TIM_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [CNT_W-1:0] count_i,
    input logic [TIM_W-1:0] t_hi_i,
    input logic             ser_clk_o,
    input logic             ser_dat_oe_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             byte_vld_o,
    input logic [21:0]      byte_addr_o
);
    logic [TIM_W:0]  hi_run;
    logic [TIM_W:0]  hi_want;
    logic [CNT_W-1:0] n_seen, n_want;
    logic [21:0]     last_addr;
    logic            have_one;

    assign hi_want = (t_hi_i == '0) ? (TIM_W+1)'(1) : (TIM_W+1)'(t_hi_i);

    // Length of the current clock high run.
    always_ff @(posedge clk) begin
        if (!rst_n) hi_run <= '0;
        else        hi_run <= ser_clk_o ? hi_run + (TIM_W+1)'(1) : '0;
    end

    // Bytes delivered and last address in the current transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_seen <= '0; n_want <= '0; last_addr <= '0; have_one <= 1'b0;
        end else if (start_i && !busy_o) begin
            n_seen <= '0; n_want <= count_i; have_one <= 1'b0;
        end else if (byte_vld_o) begin
            n_seen <= n_seen + CNT_W'(1); last_addr <= byte_addr_o; have_one <= 1'b1;
        end
    end

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    p_vld_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> busy_o);
    p_release_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ser_dat_oe_o) || $rose(ser_dat_oe_o)) |-> !ser_clk_o);
    p_idle_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ser_dat_oe_o && !ser_clk_o));
    p_high_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk_o) |-> (hi_run == hi_want));
    p_byte_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (n_seen == n_want));
    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_o && have_one) |-> (byte_addr_o == last_addr + 22'd1));
endmodule

bind pgm_read_seq pgm_read_seq_chk #(.CNT_W(CNT_W), .TIM_W(TIM_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .count_i     (count_i),
    .t_hi_i      (t_hi_i),
    .ser_clk_o   (ser_clk_o),
    .ser_dat_oe_o(ser_dat_oe_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .byte_vld_o  (byte_vld_o),
    .byte_addr_o (byte_addr_o)
);

// File: tb/pgm_read_seq_tb_top.sv
// Bench: a behavioural target model answers the serial frames; transfers
// are random (fixed seed) plus directed corner cases.
module pgm_read_seq_tb_top;
    localparam int CNT_W = 16;
    localparam int TIM_W = 8;
    localparam int BLK   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [21:0] addr_i = '0;
    logic [CNT_W-1:0] count_i = '0;
    logic rd_prot_i = 1'b0;
    logic [TIM_W-1:0] t_hi_i = 8'd1, t_lo_i = 8'd1, t_turn_i = 8'd0;
    logic ser_dat_i = 1'b0;
    logic ser_clk_o, ser_dat_o, ser_dat_oe_o, busy_o, done_o, byte_vld_o;
    logic [7:0] byte_o;
    logic [21:0] byte_addr_o;

    always #2.5 clk = ~clk;

    pgm_read_seq #(.CNT_W(CNT_W), .TIM_W(TIM_W), .BLK_BITS(BLK)) dut_i (.*);

    int vectors = 0, fails = 0;
    bit aborted = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] memf(input logic [21:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ {2'b00, a[21:16]} ^ 8'h5A;
    endfunction

    function automatic logic [15:0] expw(input int s, input logic [21:0] a);
        if (s == 0) return {8'h0E, 2'b00, a[21:16]};
        if (s == 2) return {8'h0E, a[15:8]};
        if (s == 4) return {8'h0E, a[7:0]};
        if (s == 1) return 16'h6EF8;
        if (s == 3) return 16'h6EF7;
        return 16'h6EF6;
    endfunction

    // ---------------- target model ----------------
    logic prev = 0, is_rd = 0, tprot = 0;
    int run = 0, bitcnt = 0, sstep = 0, setups = 0, nbytes = 0, rises = 0;
    logic [3:0] cmd;
    logic [15:0] word;
    logic [7:0] wreg, rb;
    logic [21:0] ptr = '0, exp_addr = '0;
    bit seen [int];
    int lo_e, hi_e, e;

    always @(negedge clk) begin
        if (rst_n) begin
            lo_e = (t_lo_i == 0) ? 1 : int'(t_lo_i);
            hi_e = (t_hi_i == 0) ? 1 : int'(t_hi_i);
            if (start_i && !busy_o) begin
                exp_addr = addr_i; nbytes = 0; setups = 0; sstep = 0;
                seen.delete(); bitcnt = 0; rises = 0; tprot = rd_prot_i; is_rd = 0;
            end
            if (ser_clk_o != prev) begin
                if (ser_clk_o) begin
                    rises++;
                    if (bitcnt != 0) begin
                        e = lo_e + ((is_rd && bitcnt == 12) ? int'(t_turn_i) : 0);
                        chk(run == e, (is_rd && bitcnt == 12) ? "R4 turnaround low time" : "R5 low time", run, e);
                    end
                    chk(ser_dat_oe_o == !(is_rd && bitcnt >= 12), "R3 output enable", ser_dat_oe_o, !(is_rd && bitcnt >= 12));
                    if (bitcnt < 4) cmd[bitcnt] = ser_dat_o;
                    else word[bitcnt-4] = ser_dat_o;
                    if (is_rd && bitcnt >= 4 && bitcnt < 12)
                        chk(ser_dat_o == 1'b0, "R2 zero payload", ser_dat_o, 0);
                    if (is_rd && bitcnt >= 12) ser_dat_i = rb[bitcnt-12];
                end else begin
                    chk(run == hi_e, "R5 high time", run, hi_e);
                    bitcnt++;
                    if (bitcnt == 4) begin
                        is_rd = (cmd == 4'b1001);
                        chk(cmd == 4'b0000 || cmd == 4'b1001, "R2 command code", cmd, 4'b1001);
                        if (is_rd) chk(sstep == 0, "R1 read after full setup", sstep, 0);
                    end
                    if (is_rd && bitcnt == 12) begin
                        chk(ptr == exp_addr, "R7 target pointer", ptr, exp_addr);
                        rb = (tprot && !seen.exists(int'(ptr >> BLK))) ? ~memf(ptr) : memf(ptr);
                        seen[int'(ptr >> BLK)] = 1;
                        ptr = ptr + 22'd1;
                    end
                    if (bitcnt == 20) begin
                        if (!is_rd) begin
                            chk(word == expw(sstep, exp_addr), "R1 setup word", word, expw(sstep, exp_addr));
                            if (word[15:8] == 8'h0E) wreg = word[7:0];
                            else if (word == 16'h6EF8) ptr[21:16] = wreg[5:0];
                            else if (word == 16'h6EF7) ptr[15:8] = wreg;
                            else if (word == 16'h6EF6) ptr[7:0] = wreg;
                            sstep++;
                            if (sstep == 6) begin sstep = 0; setups++; end
                        end
                        bitcnt = 0; is_rd = 0;
                    end
                end
                run = 1;
            end else run++;
            prev = ser_clk_o;
            if (byte_vld_o) begin
                chk(byte_o == memf(exp_addr), "R6 byte value (R8 discard)", byte_o, memf(exp_addr));
                chk(byte_addr_o == exp_addr, "R6 byte address", byte_addr_o, exp_addr);
                exp_addr = exp_addr + 22'd1;
                nbytes++;
            end
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 195000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    function automatic int exp_setups(input logic [21:0] a, input int n, input bit p);
        int nb;
        logic [21:0] x;
        if (n == 0) return 0;
        if (!p) return 1;
        nb = 1;
        x = a;
        for (int i = 1; i < n; i++) begin
            x = x + 22'd1;
            if (x[BLK-1:0] == '0) nb++;
        end
        return 1 + nb;
    endfunction

    task automatic txn(input logic [21:0] a, input int n, input bit p,
                       input int th, input int tl, input int tt, input bit poke);
        int k;
        if (aborted) return;
        @(posedge clk); #1;
        t_hi_i = 8'(th); t_lo_i = 8'(tl); t_turn_i = 8'(tt);
        addr_i = a; count_i = CNT_W'(n); rd_prot_i = p; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        chk(busy_o == 1'b1 || n == 0, "R9 busy after start", busy_o, 1);
        k = 0;
        do begin
            @(negedge clk); #1; k++;
            if (poke && k == 40) begin
                addr_i = ~a; count_i = 1; start_i = 1'b1;
            end else start_i = 1'b0;
        end while (!done_o && k < 60000);
        start_i = 1'b0;
        if (!done_o) begin
            chk(0, "R9 done never seen", 0, 1);
            aborted = 1;
            return;
        end
        chk(!busy_o, "R9 busy low at done", busy_o, 0);
        chk(nbytes == n, poke ? "R9 start while busy ignored" : "R10 byte count", nbytes, n);
        chk(setups == exp_setups(a, n, p), p ? "R8 pointer reloads" : "R7 single pointer load",
            setups, exp_setups(a, n, p));
        if (n == 0) chk(rises == 0, "R10 no clocks for zero count", rises, 0);
        @(negedge clk); #1;
        chk(!done_o, "R9 done one cycle", done_o, 0);
    endtask

    initial begin
        void'($urandom(32'd715));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!ser_clk_o && !ser_dat_o && ser_dat_oe_o, "R11 reset lines", {ser_clk_o, ser_dat_o, ser_dat_oe_o}, 3'b001);
        chk(!busy_o && !done_o && !byte_vld_o, "R11 reset status", {busy_o, done_o, byte_vld_o}, 0);
        txn(22'h012345, 3, 0, 2, 2, 3, 0);          // R1 R2 R6 basic
        txn(22'h3FFFFE, 4, 0, 1, 1, 0, 0);          // R7 wrap
        txn(22'h00010E, 4, 1, 1, 2, 2, 0);          // R8 block crossing
        txn(22'h000000, 0, 0, 1, 1, 1, 0);          // R10 zero count
        txn(22'h2A5A5A, 5, 0, 2, 1, 1, 1);          // R9 start while busy
        txn(22'h155550, 2, 0, 0, 0, 0, 0);          // R5 zero timings clamp
        txn(22'h0ABCDE, 2, 0, 1, 3, 20, 0);         // R4 long turnaround
        txn(22'h3FFFFF, 3, 1, 1, 1, 2, 0);          // R8 with wrap
        for (int i = 0; i < 12; i++)
            txn(22'($urandom), int'($urandom_range(1, 12)), 1'($urandom),
                int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                int'($urandom_range(0, 6)), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule